// File: doc/BRIEF.md
# Receive link qualification and fault monitor

This block is the per-channel control logic of a serial receiver. Each bit clock it takes one received bit from one of two serial inputs and watches how often the selected stream changes level. It combines that density verdict with status flags from the analog front end: amplitude good, rate in range, channel enabled and reference clock present. From these it decides whether the clock-recovery loop may follow the incoming data or must fall back to the local reference clock.

It also drives an active-low link-fault flag. The amplitude detector and the PLL stay outside the block and appear only as input flags.

The bit stream enters on a valid/ready pair. `in_ready` is tied high, so the block never applies back-pressure. A bit counts only in a cycle where `in_valid` is high. When `in_valid` is low, the transition-density state holds. Every other pin is a plain level control or status signal.

Top module: `rx_link_qual`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `lock_ref`=1, `link_fault_n`=0 and `src_primary`=1, and the density run count and the previous-bit memory clear to 0.
- R2: `src_primary` takes the value of `sel_primary` one clock later. `sel_primary`=1 routes `bit_pri` into the density check and `sel_primary`=0 routes `bit_sec`.
- R3: The density check counts the accepted bits that equal the previously accepted bit. It fails when 60 such bits follow the last level change, or follow reset, with no change between them.
- R4: A failed density check returns to passing on the first accepted bit that differs from the previous accepted bit, and that bit restarts the count at zero.
- R5: With `det_en`=1 and `force_local_n`=1, `lock_ref` becomes 1 one clock after any of three conditions: `amp_ok` low, `rate_ok` low, or density failed. Otherwise it becomes 0.
- R6: With `det_en`=0 and `force_local_n`=1, `lock_ref` one clock later equals the inverse of `rate_ok`. Amplitude and density have no effect on it.
- R7: `force_local_n`=0 forces `lock_ref`=1 and `link_fault_n`=0 one clock later, whatever the data and the other flags are.
- R8: `link_fault_n` one clock later is 0 when any of six causes holds, and 1 otherwise. The causes are: `rate_ok` low, `amp_ok` low, density failed, `chan_en` low, `force_local_n` low, `ref_present` low. This holds for either value of `det_en`.
- R9: A cycle with `in_valid`=0 leaves the density state unchanged.
- R10: `in_ready` is 1 in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A received bit is present this cycle |
| in_ready | output | 1 | Always 1; the block never stalls |
| bit_pri | input | 1 | Bit from the primary serial input |
| bit_sec | input | 1 | Bit from the secondary serial input |
| sel_primary | input | 1 | 1 selects the primary input, 0 the secondary |
| det_en | input | 1 | Strap: 1 adds the amplitude and density checks to the rate check |
| force_local_n | input | 1 | Active low: forces the loop onto the reference clock |
| amp_ok | input | 1 | Signal amplitude above threshold |
| rate_ok | input | 1 | Data rate within the selected range |
| chan_en | input | 1 | Receive channel enabled |
| ref_present | input | 1 | Reference clock detected |
| lock_ref | output | 1 | 1 requests the loop to lock to the reference clock |
| src_primary | output | 1 | Registered indication of the selected input |
| link_fault_n | output | 1 | Link fault, active low |

## Verification
The density check is driven in several ways:
- alternating bits, which never fail;
- a run that stops one bit short of the limit and one that reaches it;
- runs broken up by cycles without `in_valid`, which tells a count of accepted bits apart from a count of clock cycles;
- two inputs that carry different patterns while the select toggles, which shows which input feeds the check.

The lock decision is run with the strap high and low under pseudo-random amplitude and rate flags. The low-strap runs happen while density has failed, so any leak of the extra checks into the decision shows up.

All six fault causes are exercised one at a time and then at random, alongside forced-local pulses.

// File: rtl/rlq_pkg.sv
package rlq_pkg;
  // status flags reported by the analog front end
  typedef struct packed {
    logic amp_ok;
    logic rate_ok;
    logic chan_en;
    logic ref_present;
  } rlq_status_t;

  // registered decision outputs
  typedef struct packed {
    logic lock_ref;
    logic fault_n;
  } rlq_decision_t;

  localparam rlq_decision_t RLQ_DECISION_RST = '{lock_ref: 1'b1, fault_n: 1'b0};
endpackage

// File: rtl/rlq_input_mux.sv
module rlq_input_mux (
  input  logic clk,
  input  logic rst,
  input  logic sel_primary,
  input  logic bit_pri,
  input  logic bit_sec,
  output logic bit_sel,
  output logic src_primary
);
  assign bit_sel = sel_primary ? bit_pri : bit_sec;

  always_ff @(posedge clk) begin
    if (rst) src_primary <= 1'b1;
    else     src_primary <= sel_primary;
  end

  p_sel_follow_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (src_primary == $past(sel_primary)));
endmodule

// File: rtl/rlq_density_mon.sv
module rlq_density_mon #(
  parameter int LIMIT = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic bit_in,
  output logic dens_fail
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] run_q, run_d;
  logic          prev_q;
  logic          edge_seen;

  assign edge_seen = (bit_in != prev_q);

  always_comb begin
    run_d = run_q;
    if (in_valid) begin
      if (edge_seen)           run_d = '0;
      else if (run_q != LIM_V) run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      prev_q    <= 1'b0;
      dens_fail <= 1'b0;
    end else if (in_valid) begin
      run_q     <= run_d;
      prev_q    <= bit_in;
      dens_fail <= (run_d == LIM_V);
    end
  end

  p_fail_at_limit_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !edge_seen && run_q == LIM_V - 1'b1) |=> dens_fail);
  p_clear_on_edge_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && edge_seen) |=> (!dens_fail && run_q == '0));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dens_fail) && $stable(run_q) && $stable(prev_q)));
endmodule

// File: rtl/rlq_lock_ctrl.sv
module rlq_lock_ctrl
  import rlq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          det_en,
  input  logic          force_local_n,
  input  logic          dens_fail,
  input  rlq_status_t   stat,
  output rlq_decision_t dec
);
  logic qual_ok;
  logic fault_any;

  always_comb begin
    if (det_en) qual_ok = stat.amp_ok && stat.rate_ok && !dens_fail;
    else        qual_ok = stat.rate_ok;
  end

  assign fault_any = !stat.rate_ok || !stat.amp_ok || dens_fail ||
                     !stat.chan_en || !force_local_n || !stat.ref_present;

  always_ff @(posedge clk) begin
    if (rst) dec <= RLQ_DECISION_RST;
    else begin
      dec.lock_ref <= !force_local_n || !qual_ok;
      dec.fault_n  <= !fault_any;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (dec.lock_ref && !dec.fault_n));
  p_strap_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (det_en && force_local_n && stat.amp_ok && stat.rate_ok && !dens_fail) |=> !dec.lock_ref);
  p_strap_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (!det_en && force_local_n) |=> (dec.lock_ref == !$past(stat.rate_ok)));
  p_force_local_r7: assert property (@(posedge clk) disable iff (rst)
    !force_local_n |=> (dec.lock_ref && !dec.fault_n));
  p_no_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (stat.rate_ok && stat.amp_ok && !dens_fail && stat.chan_en && force_local_n &&
     stat.ref_present) |=> dec.fault_n);
endmodule

// File: rtl/rx_link_qual.sv
module rx_link_qual
  import rlq_pkg::*;
#(
  parameter int DENSITY_LIMIT = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic bit_pri,
  input  logic bit_sec,
  input  logic sel_primary,
  input  logic det_en,
  input  logic force_local_n,
  input  logic amp_ok,
  input  logic rate_ok,
  input  logic chan_en,
  input  logic ref_present,
  output logic lock_ref,
  output logic src_primary,
  output logic link_fault_n
);
  logic          bit_sel;
  logic          dens_fail;
  rlq_status_t   stat;
  rlq_decision_t dec;

  assign in_ready = 1'b1;
  assign stat = '{amp_ok: amp_ok, rate_ok: rate_ok, chan_en: chan_en, ref_present: ref_present};

  rlq_input_mux u_mux (
    .clk(clk), .rst(rst), .sel_primary(sel_primary), .bit_pri(bit_pri),
    .bit_sec(bit_sec), .bit_sel(bit_sel), .src_primary(src_primary)
  );

  rlq_density_mon #(.LIMIT(DENSITY_LIMIT)) u_dens (
    .clk(clk), .rst(rst), .in_valid(in_valid), .bit_in(bit_sel), .dens_fail(dens_fail)
  );

  rlq_lock_ctrl u_ctrl (
    .clk(clk), .rst(rst), .det_en(det_en), .force_local_n(force_local_n),
    .dens_fail(dens_fail), .stat(stat), .dec(dec)
  );

  assign lock_ref     = dec.lock_ref;
  assign link_fault_n = dec.fault_n;
endmodule

// File: tb/sim_rx_link_qual.sv
module sim_rx_link_qual;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, bit_pri = 1'b0, bit_sec = 1'b0, sel_primary = 1'b1;
  logic det_en = 1'b1, force_local_n = 1'b1, amp_ok = 1'b1, rate_ok = 1'b1;
  logic chan_en = 1'b1, ref_present = 1'b1;
  logic in_ready, lock_ref, src_primary, link_fault_n;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int   m_run = 0;
  bit   m_prev = 0, m_dfail = 0;
  bit   m_lock = 1, m_fault_n = 0, m_src = 1;

  always #4 clk = ~clk;

  rx_link_qual u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .bit_pri(bit_pri), .bit_sec(bit_sec), .sel_primary(sel_primary),
    .det_en(det_en), .force_local_n(force_local_n), .amp_ok(amp_ok),
    .rate_ok(rate_ok), .chan_en(chan_en), .ref_present(ref_present),
    .lock_ref(lock_ref), .src_primary(src_primary), .link_fault_n(link_fault_n)
  );

  always @(posedge clk) begin
    bit b;
    bit ok;
    cycles++;
    if (rst) begin
      m_run = 0; m_prev = 0; m_dfail = 0;
      m_lock = 1; m_fault_n = 0; m_src = 1;
    end else begin
      ok = det_en ? (amp_ok && rate_ok && !m_dfail) : rate_ok;
      m_lock = !force_local_n || !ok;
      m_fault_n = rate_ok && amp_ok && !m_dfail && chan_en && force_local_n && ref_present;
      m_src = sel_primary;
      b = sel_primary ? bit_pri : bit_sec;
      if (in_valid) begin
        if (b != m_prev) m_run = 0;
        else if (m_run < 60) m_run++;
        m_prev = b;
        m_dfail = (m_run == 60);
      end
    end
  end

  task automatic check1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic compare();
    check1("lock_ref", lock_ref, m_lock);
    check1("link_fault_n", link_fault_n, m_fault_n);
    check1("src_primary", src_primary, m_src);
    checks++;
    if (in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10 in_ready actual=%b expected=1", in_ready);
    end
  endtask

  // one cycle: compare at negedge, then drive new inputs
  task automatic step(logic v, logic p, logic s);
    @(negedge clk);
    compare();
    in_valid = v; bit_pri = p; bit_sec = s;
  endtask

  task automatic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) step(1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    // R3: alternating then a long run, with strap high and all flags good
    tag = "R3";
    for (int i = 0; i < 20; i++) step(1'b1, i[0], 1'b0);
    for (int i = 0; i < 59; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 70; i++) step(1'b1, 1'b0, 1'b0);
    // R4: first edge clears failure
    tag = "R4";
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b1, i[0], 1'b0);
    // R9: gaps without valid must not advance the count
    tag = "R9";
    for (int i = 0; i < 150; i++) step(i[1], 1'b1, ~i[0]);
    step(1'b1, 1'b0, 1'b0);
    // R2: secondary toggles, primary constant; switch select
    tag = "R2";
    sel_primary = 1'b0;
    for (int i = 0; i < 80; i++) step(1'b1, 1'b1, i[0]);
    sel_primary = 1'b1;
    for (int i = 0; i < 80; i++) step(1'b1, 1'b1, i[0]);
    sel_primary = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, i[0]);
    sel_primary = 1'b1;
    // R5: strap high, random amplitude and rate
    tag = "R5";
    for (int i = 0; i < 200; i++) begin
      rnd(); amp_ok = lfsr[0] | lfsr[3]; rate_ok = lfsr[1] | lfsr[5];
      step(1'b1, lfsr[2] | (i > 100), 1'b0);
    end
    // R6: strap low, density failed and amplitude low, rate random
    tag = "R6";
    det_en = 1'b0; amp_ok = 1'b0;
    for (int i = 0; i < 150; i++) begin
      rnd(); rate_ok = lfsr[4];
      step(1'b1, 1'b1, 1'b0);
    end
    amp_ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      rnd(); rate_ok = lfsr[4];
      step(1'b1, i[0], 1'b0);
    end
    // R7: force local clock pulses
    tag = "R7";
    rate_ok = 1'b1; det_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      force_local_n = !(i % 7 == 3 || i % 11 < 2);
      step(1'b1, i[0], 1'b0);
    end
    force_local_n = 1'b1;
    // R8: each cause alone, then all at random
    tag = "R8";
    for (int c = 0; c < 6; c++) begin
      for (int i = 0; i < 70; i++) begin
        rate_ok = (c != 0); amp_ok = (c != 1); chan_en = (c != 3);
        force_local_n = (c != 4); ref_present = (c != 5);
        step(1'b1, (c == 2) ? 1'b0 : i[0], 1'b0);
      end
      for (int i = 0; i < 4; i++) step(1'b1, i[0], 1'b0);
    end
    for (int i = 0; i < 400; i++) begin
      rnd();
      rate_ok = lfsr[0] | lfsr[7]; amp_ok = lfsr[1] | lfsr[8];
      chan_en = lfsr[2] | lfsr[9]; force_local_n = lfsr[3] | lfsr[10];
      ref_present = lfsr[4] | lfsr[11]; det_en = lfsr[5];
      sel_primary = lfsr[12] | lfsr[13];
      step(lfsr[6] | lfsr[14], lfsr[15] & (i % 90 < 20), lfsr[9]);
    end
    // R1: reset in mid-run
    tag = "R1";
    rst = 1'b1;
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule